// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for each beat of one read or write burst on a double-data-rate SDRAM. A mode-register write sets two things: how many beats a burst has (2, 4 or 8) and the order in which the beats visit the columns. The order is either sequential or interleaved.

When a read or write command arrives, the block captures the starting column. It then presents one column address per beat. The consumer moves it on to the next beat with a beat-advance enable. Only the offset field that lies inside the burst-sized aligned block is reordered. All column bits above that field are copied from the starting column.

In sequential order the offset counts upward from the start and wraps inside the aligned block. In interleaved order the offset is the start offset XOR the beat number. A last-beat flag marks the final beat. A new command presented together with the advance on the final beat chains a second burst directly onto the first, with no idle cycle.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `col_valid` and `col_last` are low, the burst length is 2 and the order is sequential.
- R2: A mode write with `mrs_addr[2:0]` equal to 1, 2 or 3 sets the burst length to 2, 4 or 8 respectively.
- R3: A mode write with `mrs_addr[2:0]` equal to 0 or 4 to 7 is reserved. It changes neither the length nor the order.
- R4: In a mode write with a valid length code, `mrs_addr[3]` = 0 selects sequential order and 1 selects interleaved order.
- R5: A mode write is ignored while `col_valid` is high, and also in a cycle in which `cmd_valid` is high.
- R6: A command accepted while idle raises `col_valid` one cycle later, with `col_addr` equal to `cmd_col` and `col_last` low.
- R7: While `col_valid` is high and `beat_en` is low, `col_addr` and `col_last` hold. Each `beat_en` moves the outputs to the next beat in the following cycle.
- R8: In sequential order, beat k presents offset (start + k) mod L, where L is the burst length and the offset field is the low log2(L) column bits.
- R9: In interleaved order, beat k presents offset start XOR k within the low log2(L) column bits.
- R10: Column bits at and above bit log2(L) equal those of `cmd_col` on every beat.
- R11: `col_last` is high exactly on beat L-1. A `beat_en` on that beat without a command makes the block idle in the next cycle.
- R12: A command presented together with `beat_en` on the last beat starts a new burst in the next cycle, with no idle cycle.
- R13: A command presented while a burst is in progress, other than on the last beat together with `beat_en`, is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mrs_valid | input | 1 | Mode register write strobe |
| mrs_addr | input | 4 | Mode bits: [2:0] length code, [3] order |
| cmd_valid | input | 1 | Read or write command strobe |
| cmd_col | input | COL_W | Starting column of the burst |
| beat_en | input | 1 | Consume current beat and advance |
| col_valid | output | 1 | A burst beat is being presented |
| col_addr | output | COL_W | Column address of the current beat |
| col_last | output | 1 | Current beat is the final one |

## Verification
The bench sweeps every length and order against all eight start offsets, with several different upper column patterns. This catches a design that wraps past the aligned block in sequential order: it would carry into the upper column bits. It also catches a design that swaps the two orders, or that masks the offset with the wrong width.

Stalls in the middle of a burst expose a sequencer that advances without `beat_en`. A chained command on the final beat exposes one that inserts an idle cycle or drops the new start column. Mode writes issued during a burst, together with a command, or with reserved codes are each followed by a burst whose length shows whether the write was wrongly applied. A command issued mid-burst shows whether the block wrongly restarts.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int OFF_W = 3;
  localparam int LEN_W = 2;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_XOR = 1'b1
  } burst_order_e;
endpackage

// File: rtl/bsq_mode_reg.sv
module bsq_mode_reg
  import burst_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             mrs_valid,
  input  logic [3:0]       mrs_addr,
  input  logic             busy,
  input  logic             active,
  output logic [LEN_W-1:0] len_log2,
  output burst_order_e     order
);
  logic code_ok;
  assign code_ok = (mrs_addr[2:0] == 3'd1) || (mrs_addr[2:0] == 3'd2) ||
                   (mrs_addr[2:0] == 3'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      len_log2 <= LEN_W'(1);
      order    <= ORD_SEQ;
    end else if (mrs_valid && !busy && code_ok) begin
      len_log2 <= mrs_addr[LEN_W-1:0];
      order    <= burst_order_e'(mrs_addr[3]);
    end
  end

  assert_mode_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    active |=> ($stable(len_log2) && $stable(order)));

  assert_len_legal_R2: assert property (@(posedge clk) disable iff (rst)
    (len_log2 != 2'd0));
endmodule

// File: rtl/bsq_addr_calc.sv
module bsq_addr_calc
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base,
  input  logic [OFF_W-1:0] idx,
  input  logic [LEN_W-1:0] len_log2,
  input  burst_order_e     order,
  output logic [COL_W-1:0] addr
);
  logic [OFF_W-1:0] seq_off;
  logic [OFF_W-1:0] xor_off;
  logic [OFF_W-1:0] sel_off;

  assign seq_off = base[OFF_W-1:0] + idx;
  assign xor_off = base[OFF_W-1:0] ^ idx;
  assign sel_off = (order == ORD_XOR) ? xor_off : seq_off;

  for (genvar b = 0; b < OFF_W; b++) begin : g_off_bit
    localparam logic [LEN_W-1:0] BPOS = LEN_W'(b);
    assign addr[b] = (BPOS < len_log2) ? sel_off[b] : base[b];
  end

  assign addr[COL_W-1:OFF_W] = base[COL_W-1:OFF_W];
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mrs_valid,
  input  logic [3:0]       mrs_addr,
  input  logic             cmd_valid,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             beat_en,
  output logic             col_valid,
  output logic [COL_W-1:0] col_addr,
  output logic             col_last
);
  logic [LEN_W-1:0] len_log2;
  burst_order_e     order;
  logic [COL_W-1:0] base;
  logic [OFF_W-1:0] idx;
  logic [OFF_W-1:0] next_idx;
  logic [OFF_W-1:0] last_idx;
  logic [COL_W-1:0] nxt_addr;
  logic             cmd_fire;
  logic             step;
  logic             finish;

  bsq_mode_reg i_mode (
    .clk      (clk),
    .rst      (rst),
    .mrs_valid(mrs_valid),
    .mrs_addr (mrs_addr),
    .busy     (col_valid | cmd_valid),
    .active   (col_valid),
    .len_log2 (len_log2),
    .order    (order)
  );

  assign last_idx = OFF_W'((1 << len_log2) - 1);
  assign next_idx = idx + OFF_W'(1);
  assign cmd_fire = cmd_valid && (!col_valid || (beat_en && col_last));
  assign step     = col_valid && beat_en && !col_last;
  assign finish   = col_valid && beat_en && col_last;

  bsq_addr_calc #(.COL_W(COL_W)) i_calc (
    .base    (base),
    .idx     (next_idx),
    .len_log2(len_log2),
    .order   (order),
    .addr    (nxt_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      col_valid <= 1'b0;
      col_last  <= 1'b0;
      col_addr  <= '0;
      base      <= '0;
      idx       <= '0;
    end else if (cmd_fire) begin
      col_valid <= 1'b1;
      col_last  <= 1'b0;
      col_addr  <= cmd_col;
      base      <= cmd_col;
      idx       <= '0;
    end else if (step) begin
      idx      <= next_idx;
      col_addr <= nxt_addr;
      col_last <= (next_idx == last_idx);
    end else if (finish) begin
      col_valid <= 1'b0;
      col_last  <= 1'b0;
    end
  end

  assert_last_in_burst_R11: assert property (@(posedge clk) disable iff (rst)
    col_last |-> col_valid);

  assert_end_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (finish && !cmd_valid) |=> !col_valid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (col_valid && !beat_en) |=> (col_valid && $stable(col_addr) && $stable(col_last)));

  assert_advance_R7: assert property (@(posedge clk) disable iff (rst)
    step |=> col_valid);

  assert_upper_kept_R10: assert property (@(posedge clk) disable iff (rst)
    step |=> (col_addr[COL_W-1:OFF_W] == $past(col_addr[COL_W-1:OFF_W])));

  assert_seq_step_R8: assert property (@(posedge clk) disable iff (rst)
    (step && order == ORD_SEQ) |=>
      (((col_addr - $past(col_addr)) & {{(COL_W-OFF_W){1'b0}}, $past(last_idx)})
        == COL_W'(1)));

  assert_chain_R12: assert property (@(posedge clk) disable iff (rst)
    (finish && cmd_valid) |=> (col_valid && !col_last && col_addr == $past(cmd_col)));

  assert_start_R6: assert property (@(posedge clk) disable iff (rst)
    (!col_valid && cmd_valid) |=> (col_valid && col_addr == $past(cmd_col)));
endmodule

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 10;

  logic clk = 1'b0;
  logic rst;
  logic mrs_valid;
  logic [3:0] mrs_addr;
  logic cmd_valid;
  logic [COL_W-1:0] cmd_col;
  logic beat_en;
  logic col_valid;
  logic [COL_W-1:0] col_addr;
  logic col_last;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) i_burst_col_seq (
    .clk(clk), .rst(rst), .mrs_valid(mrs_valid), .mrs_addr(mrs_addr),
    .cmd_valid(cmd_valid), .cmd_col(cmd_col), .beat_en(beat_en),
    .col_valid(col_valid), .col_addr(col_addr), .col_last(col_last)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_col(input int s, input int len, input int ord, input int k);
    int m = len - 1;
    int off = (ord != 0) ? ((s ^ k) & m) : ((s + k) & m);
    return (s & ~m) | off;
  endfunction

  task automatic mrs(input logic [3:0] code, input logic with_cmd, input int col);
    @(negedge clk);
    mrs_valid = 1'b1; mrs_addr = code;
    cmd_valid = with_cmd; cmd_col = COL_W'(col);
    @(negedge clk);
    mrs_valid = 1'b0; cmd_valid = 1'b0;
  endtask

  task automatic start_cmd(input int col);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_col = COL_W'(col);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Walk all beats of a burst that was already started; check each beat.
  task automatic walk(input string req, input int s, input int len, input int ord,
                      input bit stall, input bit idle_after);
    for (int k = 0; k < len; k++) begin
      chk({req, " valid"}, int'(col_valid), 1);
      chk({req, " addr"}, int'(col_addr), exp_col(s, len, ord, k));
      chk({"R11 last"}, int'(col_last), (k == len - 1) ? 1 : 0);
      if (stall && k == 1) begin
        @(negedge clk);
        chk("R7 hold addr", int'(col_addr), exp_col(s, len, ord, k));
        chk("R7 hold valid", int'(col_valid), 1);
      end
      beat_en = 1'b1;
      @(negedge clk);
      beat_en = 1'b0;
    end
    if (idle_after) begin
      chk("R11 idle after last", int'(col_valid), 0);
      chk("R11 last low when idle", int'(col_last), 0);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int cols[3];
    cols[0] = 0; cols[1] = 1016; cols[2] = 296;
    rst = 1'b1; mrs_valid = 1'b0; mrs_addr = '0; cmd_valid = 1'b0;
    cmd_col = '0; beat_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle, default length 2
    chk("R1 valid after reset", int'(col_valid), 0);
    chk("R1 last after reset", int'(col_last), 0);
    start_cmd(3);
    chk("R6 addr on start", int'(col_addr), 3);
    walk("R1 default len2", 3, 2, 0, 0, 1);

    // R2 R4 R8 R9 R10: sweep lengths, orders, offsets, upper bits
    for (int lc = 1; lc <= 3; lc++) begin
      for (int ord = 0; ord < 2; ord++) begin
        mrs(4'((ord << 3) | lc), 1'b0, 0);
        for (int u = 0; u < 3; u++) begin
          for (int s = 0; s < 8; s++) begin
            int col = (cols[u] & ~7) | s;
            start_cmd(col);
            walk((ord != 0) ? "R9 interleave" : "R8 sequential", col, 1 << lc, ord,
                 (s == 2), 1);
            chk("R10 upper bits", int'(col_addr) >> lc, col >> lc);
          end
        end
      end
    end

    // R3: reserved codes leave len4 sequential in place
    mrs(4'b0010, 1'b0, 0);
    mrs(4'b1000, 1'b0, 0);
    mrs(4'b1101, 1'b0, 0);
    start_cmd(5);
    walk("R3 reserved ignored", 5, 4, 0, 0, 1);

    // R5: mode write during a burst is ignored
    start_cmd(9);
    mrs(4'b1011, 1'b0, 0);
    walk("R5 busy continues", 9, 4, 0, 0, 1);
    start_cmd(9);
    walk("R5 write during burst ignored", 9, 4, 0, 0, 1);
    // R5: mode write together with a command is ignored
    mrs(4'b1011, 1'b1, 6);
    walk("R5 write with cmd ignored", 6, 4, 0, 0, 1);

    // R13: command mid-burst ignored
    start_cmd(17);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_col = COL_W'(40);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R13 addr kept", int'(col_addr), 17);
    walk("R13 burst continues", 17, 4, 0, 0, 1);

    // R12: chained burst on last beat, interleaved len 8
    mrs(4'b1011, 1'b0, 0);
    start_cmd(130);
    for (int k = 0; k < 7; k++) begin
      beat_en = 1'b1;
      @(negedge clk);
    end
    chk("R12 on last", int'(col_last), 1);
    cmd_valid = 1'b1; cmd_col = COL_W'(77);
    @(negedge clk);
    cmd_valid = 1'b0; beat_en = 1'b0;
    chk("R12 no gap valid", int'(col_valid), 1);
    chk("R12 new start", int'(col_addr), 77);
    chk("R12 last cleared", int'(col_last), 0);
    walk("R12 chained burst", 77, 8, 1, 1, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule